// File: doc/BRIEF.md
# MDIO Management Master with Programmable Output Hold

This block drives the two-wire PHY management bus from a chip's system clock. It generates the management clock (MDC) through a programmable divider and runs complete read and write frames on a split bidirectional data line: `mdio_o`, `mdio_oe` and `mdio_i`, to be joined by a pad. A single control register sets the MDC divider and an output hold count.

At high system clock rates, a data line that changes right after the MDC rising edge can violate the 10 ns hold requirement at the PHY. The master therefore keeps the driven bit (and its output enable) unchanged for HOLDTIME+1 system-clock cycles after each rising MDC edge. If the falling MDC edge comes sooner, the change happens at the falling edge instead. With a clock at or below 100 MHz, HOLDTIME=0 is enough. Near 150 MHz, HOLDTIME=1 is needed.

A command gives the direction, PHY address, register address and write data. When the frame ends, the master raises `done` for one cycle and, for a read, presents the returned word on `rd_data`.

Top module: `mdio_master`

## Requirements
- R1: After reset, `mdc`, `mdio_oe`, `busy` and `done` are low, and `rd_data` and `cfg_rdata` read zero.
- R2: A write to the control register always accepts all 32 bits. The MDC divider is bits [6:1], HOLDTIME is bits [10:8], and every other bit reads back as zero.
- R3: `mdc` is low while idle. During a frame, every MDC half-period, including the first low phase after a command is taken, lasts divider+1 system-clock cycles.
- R4: While the divider is zero, a command is ignored: `busy` stays low and `mdc` does not toggle.
- R5: A write frame (`cmd_read`=0) presents one bit per MDC rising edge, in this order: 32 ones, start 01, opcode 01, the PHY address MSB first, the register address MSB first, turnaround 10, then 16 data bits MSB first. `mdio_oe` is high at every rising edge of the frame.
- R6: A read frame (`cmd_read`=1) sends the opcode as 10. It holds `mdio_oe` low from the first turnaround bit (rising edge 47 of 64) to the end of the frame. It samples `mdio_i` on rising edges 49 to 64, MSB first, and shows the word on `rd_data` from the `done` cycle onward.
- R7: `mdio_o` and `mdio_oe` never change on an MDC rising edge. Each bit change after a rising edge occurs min(HOLDTIME+1, divider+1) system-clock cycles after that edge.
- R8: The MDC falling edge that follows the 64th rising edge ends the frame. In that cycle `done` is high for exactly one cycle, and `busy`, `mdc` and `mdio_oe` are low.
- R9: A command presented while a frame is in progress is ignored. The current frame's bits are unchanged, only one `done` is produced, and no second frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 32 | Control register write value |
| cfg_rdata | output | 32 | Control register read value |
| cmd_valid | input | 1 | Command strobe, taken when idle and divider non-zero |
| cmd_read | input | 1 | 1 = read frame, 0 = write frame |
| cmd_phy | input | 5 | PHY address |
| cmd_reg | input | 5 | Register address |
| cmd_wdata | input | 16 | Write data |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| rd_data | output | 16 | Last word read |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input value |

## Verification
The hold expiry and the MDC falling edge can land in the same cycle, so both try to advance the bit at once. This happens exactly when HOLDTIME equals the divider, and the case where HOLDTIME exceeds the divider forces the falling edge to cut the hold short. Frames are run with divider 1 and HOLDTIME 1, with divider 1 and HOLDTIME 6, and with divider 5 and HOLDTIME 7. For each of these the bench measures, at every data-line change, the cycles since the last rising edge against min(HOLDTIME+1, divider+1). It also checks that each bit is captured exactly once, in order, across the 64 rising edges.

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int DIV_W   = 6,
  parameter int HOLD_W  = 3,
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 16,
  parameter int PRE_LEN = 32,
  parameter int REG_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata,
  input  logic              cmd_valid,
  input  logic              cmd_read,
  input  logic [ADDR_W-1:0] cmd_phy,
  input  logic [ADDR_W-1:0] cmd_reg,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  localparam int FRAME    = PRE_LEN + 6 + 2 * ADDR_W + DATA_W;
  localparam int TA_POS   = PRE_LEN + 4 + 2 * ADDR_W;
  localparam int DAT_POS  = TA_POS + 2;
  localparam int CNT_W    = $clog2(FRAME);
  localparam int HOLD_LSB = DIV_W + 2;
  localparam int RB_W     = HOLD_LSB + HOLD_W;

  logic [DIV_W-1:0]  div_q, hcnt;
  logic [HOLD_W-1:0] hold_q, hold_cnt;
  logic [CNT_W-1:0]  bitn;
  logic [FRAME-1:0]  sh;
  logic [DATA_W-1:0] rsh;
  logic              pend, rd_q;

  wire tick  = busy && (hcnt >= div_q);
  wire rise  = tick && !mdc;
  wire fall  = tick && mdc;
  wire last  = (bitn == CNT_W'(FRAME - 1));
  wire adv   = pend && (fall || (!last && hold_cnt == hold_q));
  wire start = cmd_valid && !busy && (div_q != '0);

  assign mdio_o    = sh[FRAME-1];
  assign cfg_rdata = REG_W'({hold_q, 1'b0, div_q, 1'b0});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q    <= '0;
      hold_q   <= '0;
      hcnt     <= '0;
      hold_cnt <= '0;
      bitn     <= '0;
      sh       <= '0;
      rsh      <= '0;
      pend     <= 1'b0;
      rd_q     <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
      mdc      <= 1'b0;
      mdio_oe  <= 1'b0;
      rd_data  <= '0;
    end else begin
      done <= 1'b0;
      if (cfg_we) begin
        div_q  <= cfg_wdata[DIV_W:1];
        hold_q <= cfg_wdata[HOLD_LSB +: HOLD_W];
      end
      if (start) begin
        busy     <= 1'b1;
        mdc      <= 1'b0;
        hcnt     <= '0;
        bitn     <= '0;
        pend     <= 1'b0;
        hold_cnt <= '0;
        rd_q     <= cmd_read;
        mdio_oe  <= 1'b1;
        sh <= {{PRE_LEN{1'b1}}, 2'b01, cmd_read ? 2'b10 : 2'b01, cmd_phy, cmd_reg,
               cmd_read ? 2'b00 : 2'b10, cmd_read ? DATA_W'(0) : cmd_wdata};
      end else if (busy) begin
        hcnt <= tick ? '0 : hcnt + 1'b1;
        if (tick) mdc <= ~mdc;
        if (rise) begin
          pend     <= 1'b1;
          hold_cnt <= '0;
          if (rd_q && bitn >= CNT_W'(DAT_POS)) rsh <= {rsh[DATA_W-2:0], mdio_i};
        end else if (adv) begin
          pend <= 1'b0;
          if (last) begin
            busy    <= 1'b0;
            done    <= 1'b1;
            mdio_oe <= 1'b0;
            sh      <= '0;
            if (rd_q) rd_data <= rsh;
          end else begin
            sh   <= sh << 1;
            bitn <= bitn + 1'b1;
            if (rd_q && bitn == CNT_W'(TA_POS - 1)) mdio_oe <= 1'b0;
          end
        end else if (pend) begin
          hold_cnt <= hold_cnt + 1'b1;
        end
      end
    end
  end

  p_mdc_idle_r3: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !mdc)
    else $error("MDC active while idle");
  p_oe_idle_r8: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !mdio_oe)
    else $error("data line driven while idle");
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done)
    else $error("done longer than one cycle");
  p_no_change_on_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mdc) |-> ($stable(mdio_o) && $stable(mdio_oe)))
    else $error("data line changed on MDC rising edge");
  p_zero_div_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && cmd_valid && div_q == '0) |=> !busy)
    else $error("frame started with divider zero");
  p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> (busy || done))
    else $error("frame ended without done");
  if (RB_W > REG_W) begin : g_bad_width
    initial $error("control fields exceed register width");
  end
endmodule

// File: tb/mdio_master_test.sv
module mdio_master_test;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic cmd_valid = 0, cmd_read = 0;
  logic [4:0] cmd_phy = '0, cmd_reg = '0;
  logic [15:0] cmd_wdata = '0, rd_data;
  logic busy, done, mdc, mdio_o, mdio_oe, mdio_i = 0;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  mdio_master uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .cmd_valid(cmd_valid), .cmd_read(cmd_read), .cmd_phy(cmd_phy), .cmd_reg(cmd_reg),
    .cmd_wdata(cmd_wdata), .busy(busy), .done(done), .rd_data(rd_data), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [31:0] v);
    @(negedge clk); cfg_we = 1; cfg_wdata = v;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic test_reset;
    chk(mdc == 0 && mdio_oe == 0, "R1 mdc/oe", {mdc, mdio_oe}, 0);
    chk(busy == 0 && done == 0, "R1 busy/done", {busy, done}, 0);
    chk(rd_data == 0 && cfg_rdata == 0, "R1 regs", {rd_data, cfg_rdata}, 0);
  endtask

  task automatic test_cfg;
    set_cfg(32'hFFFF_FFFF);
    chk(cfg_rdata == 32'h0000_077E, "R2 all ones", cfg_rdata, 32'h77E);
    set_cfg(32'hABCD_0305);
    chk(cfg_rdata == 32'h0000_0304, "R2 fields", cfg_rdata, 32'h304);
  endtask

  task automatic test_zero_div;
    int bad = 0;
    set_cfg(32'h0000_0300);
    @(negedge clk); cmd_valid = 1;
    @(negedge clk); cmd_valid = 0;
    for (int i = 0; i < 40; i++) begin
      if (busy || mdc) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R4 ignored", bad, 0);
  endtask

  task automatic run_frame(input bit rd, input logic [4:0] phy, input logic [4:0] rg,
                           input logic [15:0] wd, input logic [15:0] pat,
                           input int d, input int h, input bit poke);
    logic [63:0] got = '0, exp, mask;
    int rises = 0, since = 100, last_t = 0, cyc = 0, hbad = 0, pbad = 0, obad = 0, dones = 0;
    int hexp;
    logic pm, po, poe;
    hexp = (h + 1 < d + 1) ? h + 1 : d + 1;
    exp  = {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, phy, rg, 2'b10, rd ? pat : wd};
    mask = rd ? {46'h3FFF_FFFF_FFFF, 18'h0} : 64'hFFFF_FFFF_FFFF_FFFF;
    set_cfg(32'(d << 1) | 32'(h << 8));
    @(negedge clk);
    cmd_valid = 1; cmd_read = rd; cmd_phy = phy; cmd_reg = rg; cmd_wdata = wd;
    @(negedge clk);
    cmd_valid = 0;
    pm = mdc; po = mdio_o; poe = mdio_oe;
    while (!done && cyc < 20000) begin
      @(negedge clk); cyc++;
      if (poke) begin
        cmd_valid = (rises == 10);
        cmd_read = ~rd; cmd_phy = ~phy; cmd_reg = ~rg; cmd_wdata = ~wd;
      end
      if (mdc != pm) begin
        if (cyc - last_t != d + 1) pbad++;
        last_t = cyc;
      end
      if (mdc && !pm) begin
        if (rises < 64) got[63-rises] = mdio_o;
        if (mdio_oe != !(rd && rises >= 46)) obad++;
        rises++;
        since = 0;
      end else since++;
      if (!done && poe && (mdio_o != po || !mdio_oe) && since != hexp) hbad++;
      if (rd && rises >= 48 && rises < 64) mdio_i = pat[15 - (rises - 48)];
      dones += done;
      pm = mdc; po = mdio_o; poe = mdio_oe;
    end
    cmd_valid = 0;
    chk(pbad == 0, "R3 half period", pbad, 0);
    chk(hbad == 0, "R7 hold", hbad, 0);
    chk((got & mask) == (exp & mask), rd ? "R6 header bits" : "R5 frame bits", got & mask, exp & mask);
    chk(obad == 0, rd ? "R6 oe release" : "R5 oe driven", obad, 0);
    chk(done && rises == 64, "R8 end after 64 rises", rises, 64);
    chk(!busy && !mdc && !mdio_oe, "R8 idle at done", {busy, mdc, mdio_oe}, 0);
    if (rd) chk(rd_data == pat, "R6 read data", rd_data, pat);
    @(negedge clk);
    chk(!done, "R8 done width", done, 0);
    if (poke) begin
      for (int i = 0; i < 20; i++) begin
        if (busy) dones++;
        @(negedge clk);
      end
      chk(dones == 1, "R9 busy command ignored", dones, 1);
    end
  endtask

  initial begin
    #(10 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1;
    @(negedge clk);
    test_reset();
    test_cfg();
    test_zero_div();
    run_frame(0, 5'h11, 5'h0A, 16'hA5C3, 16'h0000, 2, 0, 0);
    run_frame(1, 5'h03, 5'h1F, 16'h0000, 16'h9E21, 3, 2, 0);
    run_frame(0, 5'h1E, 5'h01, 16'h3C5A, 16'h0000, 1, 1, 0);
    run_frame(0, 5'h00, 5'h15, 16'hFFFE, 16'h0000, 1, 6, 1);
    run_frame(1, 5'h1F, 5'h00, 16'h0000, 16'h7F81, 5, 7, 0);
    run_frame(0, 5'h0A, 5'h0C, 16'h8001, 16'h0000, 63, 0, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule